// File: doc/BRIEF.md
# Configuration EEPROM Command Unit

This block puts a small command interface in front of a 128-byte configuration store that lives on chip. Software writes a command word that holds an operation code and a byte address. It reads results back from an 8-bit data register. The available operations are: read one byte, open or close a write-enable latch, clear bits in one byte or in every byte, set one byte or every byte to 0xFF, and reload the station address.

A store write can only clear bits. The new byte is the old byte ANDed with the data register. Every modifying operation is dropped while the write-enable latch is closed.

A reload looks at byte 0. If byte 0 equals the signature 0xA5, bytes 1 to 6 are copied into a 48-bit station address and a valid flag is raised. If byte 0 holds any other value, the flag is dropped and the address keeps its old value. A reload also starts by itself on every reset.

The store is a dual-port memory with a registered read port. Any operation that touches it runs as a short sequence and handles one byte per cycle. A busy bit is high for the whole sequence, and command and data writes that arrive while it is high are ignored.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: Synchronous reset clears the data register to 0, clears the valid flag, the station address and the write-enable latch, and starts a reload. Busy is 1 right after the reset edge and falls 8 clock edges after the last reset edge. The store contents survive reset. The power-up contents are: byte 0 = 0xA5, byte k (1..6) = DEFAULT_MAC bits 8(k-1)+7:8(k-1), and all other bytes = 0xFF.
- R2: The command readback word has these fields: bit 31 = busy, bits 30:28 = the last accepted opcode, bit 8 = the valid flag, bits 6:0 = the last accepted address. All other bits read 0. Writing a command never changes the valid flag.
- R3: Opcode 0 loads the addressed byte into the data register. The value appears 2 edges after the command is accepted, and busy is high in between.
- R4: A data-register write keeps only bits 7:0. Data writes made while busy is high are ignored.
- R5: Opcode 2 opens the write-enable latch and opcode 1 closes it. Reset also closes it. Opcodes 3, 4, 5 and 6 are ignored while the latch is closed: busy stays 0 and the store is unchanged.
- R6: Opcode 3 replaces the addressed byte with (old byte AND data register). Busy is high for 2 cycles.
- R7: Opcode 4 applies the AND to all 128 bytes, one byte per cycle. Busy is high for 129 cycles.
- R8: Opcode 5 sets the addressed byte to 0xFF, with busy high for 1 cycle. Opcode 6 sets all bytes to 0xFF, with busy high for 128 cycles.
- R9: Opcode 7 takes 8 busy cycles. If byte 0 is 0xA5, station address bits 8k+7:8k take byte k+1 (k = 0..5) and the valid flag is set. Otherwise the flag is cleared and the address is unchanged.
- R10: A command written while busy is high is ignored, and the readback opcode and address fields keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word: opcode in bits 30:28, address in bits 6:0 |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data write value; only bits 7:0 are kept |
| cmd_q | output | 32 | Command readback (busy, opcode, valid flag, address) |
| data_q | output | 8 | Data register |
| mac_addr | output | 48 | Station address, byte k in bits 8k+7:8k |
| mac_loaded | output | 1 | Station address valid flag |
| busy | output | 1 | A store sequence is in progress |

## Verification
Some properties are checked on every cycle by assertions:
- the store is written only while the write-enable latch is open;
- no write lands outside the address window of the running operation;
- the data register and the command fields hold still while busy is high, except at the read capture;
- the station address changes only on the closing edge of a reload;
- the valid flag rises only on that edge.

Other behaviour can only be shown by the bench scenarios, because it needs values carried through the store over many cycles:
- AND-only writes;
- whole-array sweeps;
- the signature check on reload;
- the exact busy lengths;
- store contents that survive a reset.

// File: rtl/eecmd_pkg.sv
package eecmd_pkg;
  localparam int BYTE_W      = 8;
  localparam int CMD_W       = 32;
  localparam int CMD_ADDR_W  = 7;
  localparam int CMD_OP_LSB  = 28;
  localparam int OP_W        = 3;

  localparam logic [OP_W-1:0] OP_READ   = 3'd0;
  localparam logic [OP_W-1:0] OP_LOCK   = 3'd1;
  localparam logic [OP_W-1:0] OP_UNLOCK = 3'd2;
  localparam logic [OP_W-1:0] OP_AND1   = 3'd3;
  localparam logic [OP_W-1:0] OP_ANDALL = 3'd4;
  localparam logic [OP_W-1:0] OP_SET1   = 3'd5;
  localparam logic [OP_W-1:0] OP_SETALL = 3'd6;
  localparam logic [OP_W-1:0] OP_RELOAD = 3'd7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_WAIT,
    S_RD_CAP,
    S_AND_SWEEP,
    S_AND_DRAIN,
    S_FF_SWEEP,
    S_RLD_SWEEP,
    S_RLD_DRAIN
  } seq_state_e;
endpackage

// File: rtl/eecmd_store.sv
module eecmd_store
  import eecmd_pkg::*;
#(
  parameter int                      DEPTH       = 128,
  parameter int                      MAC_BYTES   = 6,
  parameter logic [BYTE_W-1:0]       SIG         = 8'hA5,
  parameter logic [8*MAC_BYTES-1:0]  DEFAULT_MAC = 48'h665544332211,
  localparam int                     AW          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // power-up image: signature, station address, erased remainder
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0) mem[i] = SIG;
      else if (i <= MAC_BYTES) mem[i] = DEFAULT_MAC[8*(i-1) +: 8];
      else mem[i] = '1;
    end
  end

  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/eecmd_seq.sv
module eecmd_seq
  import eecmd_pkg::*;
#(
  parameter int                DEPTH     = 128,
  parameter int                MAC_BYTES = 6,
  parameter logic [BYTE_W-1:0] SIG       = 8'hA5,
  localparam int               AW        = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_wr,
  input  logic [OP_W-1:0]           cmd_op,
  input  logic [CMD_ADDR_W-1:0]     cmd_addr,
  input  logic                      data_wr,
  input  logic [BYTE_W-1:0]         data_in,
  output logic [AW-1:0]             rd_addr,
  input  logic [BYTE_W-1:0]         rd_data,
  output logic                      wr_en,
  output logic [AW-1:0]             wr_addr,
  output logic [BYTE_W-1:0]         wr_data,
  output logic [BYTE_W-1:0]         data_q,
  output logic [OP_W-1:0]           op_q,
  output logic [CMD_ADDR_W-1:0]     addr_q,
  output logic [8*MAC_BYTES-1:0]    mac_q,
  output logic                      loaded_q,
  output logic                      busy_q
);
  localparam logic [AW-1:0] LAST_ALL = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_RLD = AW'(MAC_BYTES);

  seq_state_e state_q, state_n;
  logic [AW-1:0] ptr_q, ptr_n, last_q, last_n, pend_addr_q, pend_addr_n;
  logic pend_q, pend_n, wen_q, wen_n, loaded_n, busy_n;
  logic [BYTE_W-1:0] data_n, sig_q, sig_n;
  logic [OP_W-1:0] op_n;
  logic [CMD_ADDR_W-1:0] addr_n;
  logic [MAC_BYTES-1:0][BYTE_W-1:0] tmp_q, tmp_n;
  logic [8*MAC_BYTES-1:0] mac_n;

  always_comb begin
    state_n     = state_q;
    ptr_n       = ptr_q;
    last_n      = last_q;
    pend_n      = pend_q;
    pend_addr_n = pend_addr_q;
    wen_n       = wen_q;
    data_n      = data_q;
    op_n        = op_q;
    addr_n      = addr_q;
    sig_n       = sig_q;
    tmp_n       = tmp_q;
    mac_n       = mac_q;
    loaded_n    = loaded_q;

    // gather the reload bytes as they leave the read port
    if ((state_q == S_RLD_SWEEP || state_q == S_RLD_DRAIN) && pend_q) begin
      if (pend_addr_q == '0) sig_n = rd_data;
      for (int i = 0; i < MAC_BYTES; i++) begin
        if (pend_addr_q == AW'(i + 1)) tmp_n[i] = rd_data;
      end
    end

    case (state_q)
      S_IDLE: begin
        if (data_wr) data_n = data_in;
        if (cmd_wr) begin
          op_n   = cmd_op;
          addr_n = cmd_addr;
          case (cmd_op)
            OP_READ:   begin ptr_n = cmd_addr[AW-1:0]; state_n = S_RD_WAIT; end
            OP_LOCK:   wen_n = 1'b0;
            OP_UNLOCK: wen_n = 1'b1;
            OP_AND1: if (wen_q) begin
              ptr_n = cmd_addr[AW-1:0]; last_n = cmd_addr[AW-1:0]; state_n = S_AND_SWEEP;
            end
            OP_ANDALL: if (wen_q) begin
              ptr_n = '0; last_n = LAST_ALL; state_n = S_AND_SWEEP;
            end
            OP_SET1: if (wen_q) begin
              ptr_n = cmd_addr[AW-1:0]; last_n = cmd_addr[AW-1:0]; state_n = S_FF_SWEEP;
            end
            OP_SETALL: if (wen_q) begin
              ptr_n = '0; last_n = LAST_ALL; state_n = S_FF_SWEEP;
            end
            default: begin ptr_n = '0; last_n = LAST_RLD; state_n = S_RLD_SWEEP; end
          endcase
        end
      end
      S_RD_WAIT: state_n = S_RD_CAP;
      S_RD_CAP: begin
        data_n  = rd_data;
        state_n = S_IDLE;
      end
      S_AND_SWEEP, S_RLD_SWEEP: begin
        pend_n      = 1'b1;
        pend_addr_n = ptr_q;
        ptr_n       = ptr_q + AW'(1);
        if (ptr_q == last_q)
          state_n = (state_q == S_AND_SWEEP) ? S_AND_DRAIN : S_RLD_DRAIN;
      end
      S_AND_DRAIN: begin
        pend_n  = 1'b0;
        state_n = S_IDLE;
      end
      S_FF_SWEEP: begin
        ptr_n = ptr_q + AW'(1);
        if (ptr_q == last_q) state_n = S_IDLE;
      end
      S_RLD_DRAIN: begin
        pend_n  = 1'b0;
        state_n = S_IDLE;
        if (sig_n == SIG) begin
          for (int i = 0; i < MAC_BYTES; i++) mac_n[8*i +: 8] = tmp_n[i];
          loaded_n = 1'b1;
        end else begin
          loaded_n = 1'b0;
        end
      end
      default: state_n = S_IDLE;
    endcase

    busy_n = (state_n != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_RLD_SWEEP;
      ptr_q       <= '0;
      last_q      <= LAST_RLD;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      wen_q       <= 1'b0;
      data_q      <= '0;
      op_q        <= '0;
      addr_q      <= '0;
      sig_q       <= '0;
      tmp_q       <= '0;
      mac_q       <= '0;
      loaded_q    <= 1'b0;
      busy_q      <= 1'b1;
    end else begin
      state_q     <= state_n;
      ptr_q       <= ptr_n;
      last_q      <= last_n;
      pend_q      <= pend_n;
      pend_addr_q <= pend_addr_n;
      wen_q       <= wen_n;
      data_q      <= data_n;
      op_q        <= op_n;
      addr_q      <= addr_n;
      sig_q       <= sig_n;
      tmp_q       <= tmp_n;
      mac_q       <= mac_n;
      loaded_q    <= loaded_n;
      busy_q      <= busy_n;
    end
  end

  // store port drive
  always_comb begin
    rd_addr = ptr_q;
    wr_en   = ((state_q == S_AND_SWEEP || state_q == S_AND_DRAIN) && pend_q)
              || (state_q == S_FF_SWEEP);
    wr_addr = (state_q == S_FF_SWEEP) ? ptr_q : pend_addr_q;
    wr_data = (state_q == S_FF_SWEEP) ? '1 : (rd_data & data_q);
  end

  a_r5_write_needs_enable: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wen_q);

  a_r8_write_in_window: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= last_q));

  a_r4_data_hold_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_q && state_q != S_RD_CAP) |=> $stable(data_q));

  a_r10_cmd_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(op_q) && $stable(addr_q)));

  a_r9_mac_only_on_reload: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_RLD_DRAIN) |=> $stable(mac_q));

  a_r1_flag_rise_on_reload: assert property (@(posedge clk) disable iff (rst)
    $rose(loaded_q) |-> $past(state_q == S_RLD_DRAIN));
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eecmd_pkg::*;
#(
  parameter int                     DEPTH       = 128,
  parameter int                     MAC_BYTES   = 6,
  parameter logic [7:0]             SIG         = 8'hA5,
  parameter logic [8*MAC_BYTES-1:0] DEFAULT_MAC = 48'h665544332211
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_wr,
  input  logic [31:0]            cmd_wdata,
  input  logic                   data_wr,
  input  logic [31:0]            data_wdata,
  output logic [31:0]            cmd_q,
  output logic [7:0]             data_q,
  output logic [8*MAC_BYTES-1:0] mac_addr,
  output logic                   mac_loaded,
  output logic                   busy
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] rd_addr, wr_addr;
  logic [BYTE_W-1:0] rd_data, wr_data;
  logic wr_en;
  logic [OP_W-1:0] op_q;
  logic [CMD_ADDR_W-1:0] addr_q;
  logic unused_bits;

  assign unused_bits = ^{cmd_wdata[31], cmd_wdata[27:7], data_wdata[31:8]};

  eecmd_store #(
    .DEPTH(DEPTH), .MAC_BYTES(MAC_BYTES), .SIG(SIG), .DEFAULT_MAC(DEFAULT_MAC)
  ) u_store (
    .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  eecmd_seq #(
    .DEPTH(DEPTH), .MAC_BYTES(MAC_BYTES), .SIG(SIG)
  ) u_seq (
    .clk(clk), .rst(rst),
    .cmd_wr(cmd_wr),
    .cmd_op(cmd_wdata[CMD_OP_LSB +: OP_W]),
    .cmd_addr(cmd_wdata[CMD_ADDR_W-1:0]),
    .data_wr(data_wr), .data_in(data_wdata[BYTE_W-1:0]),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .data_q(data_q), .op_q(op_q), .addr_q(addr_q),
    .mac_q(mac_addr), .loaded_q(mac_loaded), .busy_q(busy)
  );

  assign cmd_q = {busy, op_q, 19'b0, mac_loaded, 1'b0, addr_q};
endmodule

// File: tb/eeprom_cmd_ctrl_test.sv
module eeprom_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;
  localparam int MAC_BYTES = 6;
  localparam logic [7:0] SIG = 8'hA5;
  localparam logic [47:0] DEFAULT_MAC = 48'h665544332211;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0, rst = 1'b1, cmd_wr = 1'b0, data_wr = 1'b0;
  logic [31:0] cmd_wdata = '0, data_wdata = '0;
  logic [31:0] cmd_q;
  logic [7:0] data_q;
  logic [47:0] mac_addr;
  logic mac_loaded, busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_cmd_ctrl #(.DEPTH(DEPTH), .MAC_BYTES(MAC_BYTES), .SIG(SIG),
                    .DEFAULT_MAC(DEFAULT_MAC)) uut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .cmd_q(cmd_q), .data_q(data_q),
    .mac_addr(mac_addr), .mac_loaded(mac_loaded), .busy(busy));

  // behavioural reference
  logic [7:0] m_mem [DEPTH];
  logic [7:0] m_data;
  logic [2:0] m_op, m_pend_op;
  logic [6:0] m_addr, m_pend_addr;
  logic [47:0] m_mac;
  logic m_loaded, m_wen;
  int m_cnt;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      m_mem[i] = (i == 0) ? SIG : (i <= MAC_BYTES) ? DEFAULT_MAC[8*(i-1) +: 8] : 8'hFF;
    m_cnt = 0;
  end

  function automatic void chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endfunction

  function automatic void apply_op(logic [2:0] op, logic [6:0] a);
    case (op)
      3'd0: m_data = m_mem[a];
      3'd3: m_mem[a] = m_mem[a] & m_data;
      3'd4: for (int i = 0; i < DEPTH; i++) m_mem[i] = m_mem[i] & m_data;
      3'd5: m_mem[a] = 8'hFF;
      3'd6: for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      3'd7: begin
        if (m_mem[0] == SIG) begin
          for (int k = 0; k < MAC_BYTES; k++) m_mac[8*k +: 8] = m_mem[k+1];
          m_loaded = 1'b1;
        end else m_loaded = 1'b0;
      end
      default: ;
    endcase
  endfunction

  function automatic void model_edge(logic r, logic cw, logic [31:0] cd, logic dw, logic [31:0] dd);
    if (r) begin
      m_loaded = 0; m_mac = '0; m_data = '0; m_op = '0; m_addr = '0; m_wen = 0;
      m_cnt = MAC_BYTES + 2; m_pend_op = 3'd7; m_pend_addr = '0;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) apply_op(m_pend_op, m_pend_addr);
    end else begin
      if (dw) m_data = dd[7:0];
      if (cw) begin
        m_op = cd[30:28]; m_addr = cd[6:0];
        m_pend_op = m_op; m_pend_addr = m_addr;
        case (m_op)
          3'd0: m_cnt = 2;
          3'd1: m_wen = 0;
          3'd2: m_wen = 1;
          3'd3: if (m_wen) m_cnt = 2;
          3'd4: if (m_wen) m_cnt = DEPTH + 1;
          3'd5: if (m_wen) m_cnt = 1;
          3'd6: if (m_wen) m_cnt = DEPTH;
          default: m_cnt = MAC_BYTES + 2;
        endcase
      end
    end
  endfunction

  function automatic void compare_all();
    logic b;
    b = (m_cnt > 0);
    chk("R2 command readback", 64'(cmd_q), 64'({b, m_op, 19'b0, m_loaded, 1'b0, m_addr}));
    chk("R3 data register", 64'(data_q), 64'(m_data));
    chk("R9 station address", 64'(mac_addr), 64'(m_mac));
    chk("R9 valid flag", 64'(mac_loaded), 64'(m_loaded));
    chk("R10 busy", 64'(busy), 64'(b));
  endfunction

  task automatic step(logic r, logic cw, logic [31:0] cd, logic dw, logic [31:0] dd);
    rst = r; cmd_wr = cw; cmd_wdata = cd; data_wr = dw; data_wdata = dd;
    @(posedge clk);
    model_edge(r, cw, cd, dw, dd);
    @(negedge clk);
    compare_all();
    rst = 0; cmd_wr = 0; data_wr = 0;
  endtask

  task automatic idle(); step(0, 0, '0, 0, '0); endtask
  task automatic issue(logic [2:0] op, logic [6:0] a); step(0, 1, {1'b0, op, 21'b0, a}, 0, '0); endtask
  task automatic set_data(logic [31:0] d); step(0, 0, '0, 1, d); endtask
  task automatic wait_idle(); while (m_cnt > 0) idle(); endtask
  task automatic read_byte(logic [6:0] a, output logic [7:0] v);
    issue(3'd0, a); wait_idle(); v = data_q;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    step(1, 0, '0, 0, '0);
    step(1, 0, '0, 0, '0);
    chk("R1 reset busy", 64'(busy), 64'd1);
    chk("R1 reset flag", 64'(mac_loaded), 64'd0);
    chk("R1 reset data", 64'(data_q), 64'd0);
    repeat (7) idle();
    chk("R1 busy 7 edges after reset", 64'(busy), 64'd1);
    idle();
    chk("R1 reload done after 8 edges", 64'(busy), 64'd0);
    chk("R1 address from power-up image", 64'(mac_addr), 64'(DEFAULT_MAC));
    chk("R1 flag after reset reload", 64'(mac_loaded), 64'd1);

    set_data(32'hABCD_12C3);
    chk("R4 low byte kept", 64'(data_q), 64'hC3);
    read_byte(7'd0, v);
    chk("R3 read signature", 64'(v), 64'hA5);
    read_byte(7'd3, v);
    chk("R3 read byte 3", 64'(v), 64'h33);

    set_data(32'h0);
    issue(3'd3, 7'd10);
    chk("R5 locked write not started", 64'(busy), 64'd0);
    read_byte(7'd10, v);
    chk("R5 locked write no effect", 64'(v), 64'hFF);

    issue(3'd2, 7'd0);
    chk("R2 flag kept on command", 64'(cmd_q[8]), 64'd1);
    set_data(32'h0F);
    issue(3'd3, 7'd10);
    wait_idle();
    read_byte(7'd10, v);
    chk("R6 byte AND write", 64'(v), 64'h0F);

    set_data(32'h3C);
    issue(3'd3, 7'd20);
    step(0, 1, {1'b0, 3'd0, 21'b0, 7'd5}, 1, 32'h99);
    chk("R10 busy command ignored", 64'(cmd_q[6:0]), 64'd20);
    chk("R4 busy data write ignored", 64'(data_q), 64'h3C);
    wait_idle();
    read_byte(7'd20, v);
    chk("R6 AND with held data", 64'(v), 64'h3C);

    issue(3'd5, 7'd10);
    wait_idle();
    read_byte(7'd10, v);
    chk("R8 byte erase", 64'(v), 64'hFF);

    set_data(32'h01);
    issue(3'd3, 7'd1);
    wait_idle();
    issue(3'd7, 7'd0);
    wait_idle();
    chk("R9 reload new address", 64'(mac_addr), 64'h6655_4433_2201);
    chk("R9 reload flag", 64'(mac_loaded), 64'd1);

    set_data(32'hF7);
    issue(3'd4, 7'd0);
    wait_idle();
    read_byte(7'd0, v);
    chk("R7 AND-all keeps signature", 64'(v), 64'hA5);
    read_byte(7'd20, v);
    chk("R7 AND-all byte 20", 64'(v), 64'h34);
    read_byte(7'd100, v);
    chk("R7 AND-all byte 100", 64'(v), 64'hF7);

    issue(3'd1, 7'd0);
    issue(3'd6, 7'd0);
    chk("R5 locked erase-all not started", 64'(busy), 64'd0);
    read_byte(7'd0, v);
    chk("R5 locked erase-all no effect", 64'(v), 64'hA5);

    issue(3'd2, 7'd0);
    issue(3'd6, 7'd0);
    wait_idle();
    read_byte(7'd0, v);
    chk("R8 erase-all", 64'(v), 64'hFF);
    issue(3'd7, 7'd0);
    wait_idle();
    chk("R9 bad signature clears flag", 64'(mac_loaded), 64'd0);
    chk("R9 bad signature keeps address", 64'(mac_addr), 64'h6655_4433_2201);

    step(1, 0, '0, 0, '0);
    wait_idle();
    chk("R1 store survives reset", 64'(mac_loaded), 64'd0);
    issue(3'd5, 7'd3);
    chk("R5 latch closed by reset", 64'(busy), 64'd0);
    repeat (3) idle();
    finish_up();
  end
endmodule